// File: doc/BRIEF.md
# Segmented Bus-Inversion Line Codec

This block carries a 64-byte line across a 64-bit, active-low data path while keeping the number of wires pulled low small. On the transmit side a 512-bit line is accepted in a single cycle and sent out as eight 64-bit data phases, lowest eight bytes first. Each phase is split into four 16-bit segments. A segment whose wires would put more than half of its lines low is sent complemented, and the segment's own active-low flag wire is driven to 0.

The receive side takes the bus value and the four flags for each phase. It complements every flagged segment back, and gathers eight decoded phases into a 512-bit line. `clk` is the data-phase clock: one phase per cycle, so four cycles make one bus clock and a full line fits in two bus clocks. Both directions follow the same segment rule. The bench connects them back to back.

Top module: `dbi_line_codec`

## Requirements
- R1: Segment g (g = 0..3) covers bus bits [16g+15:16g] and is governed by flag bit g alone. Flag 0 covers bits 15:0, and flag 3 covers bits 63:48.
- R2: A segment is sent complemented only when its raw value has strictly more than 8 zero bits. Exactly 8 zeros leaves the segment unchanged. 9 or more zeros complement it.
- R3: No segment of a transmitted phase ever carries more than 8 zero bits.
- R4: Flags are active-low: flag bit value 0 means the segment is complemented, and 1 means it is sent as is. A segment of all zeros goes out as 16'hFFFF with its flag at 0.
- R5: On receive, each segment whose flag is 0 is complemented back, and a segment whose flag is 1 passes through unchanged. Transmit followed by receive returns the original data.
- R6: The line accepted on an edge where `tx_line_valid` is 1 and `tx_busy` is 0 appears as 8 consecutive phases with `tx_phase_valid` high. Phase k carries line bits [64k+63:64k] and is presented after edge k+1 counted from the accepting edge.
- R7: `tx_last` is 1 on the eighth phase of a line and on no other cycle.
- R8: `tx_line_valid` is ignored while `tx_busy` is 1. A line offered then is never sent, and no phase follows the eighth phase of the current line.
- R9: The receive side collects 8 phases with `rx_phase_valid` high, phase 0 into `rx_line` bits 63:0. It raises `rx_line_valid` for exactly one cycle, after the edge that takes the eighth phase.
- R10: After reset, `tx_phase_valid`, `tx_last`, `tx_busy` and `rx_line_valid` are 0, and `tx_inv_n` is 4'hF.
- R11: The inversion decision is made again for every phase, using only that phase's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data-phase clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_line_valid | input | 1 | Offer of a line to transmit |
| tx_line | input | 512 | Line to transmit, byte 0 in bits 7:0 |
| tx_busy | output | 1 | Transmitter is sending a line |
| tx_bus | output | 64 | Encoded bus value for the current phase |
| tx_inv_n | output | 4 | Active-low per-segment inversion flags |
| tx_phase_valid | output | 1 | tx_bus/tx_inv_n hold a phase |
| tx_last | output | 1 | Current phase is the eighth of the line |
| rx_phase_valid | input | 1 | rx_bus/rx_inv_n hold a phase |
| rx_bus | input | 64 | Received bus value |
| rx_inv_n | input | 4 | Received active-low inversion flags |
| rx_line | output | 512 | Reassembled decoded line |
| rx_line_valid | output | 1 | One-cycle pulse when rx_line is complete |

## Verification
The bench builds the block with its default parameters: 64-bit phases, 16-bit segments and 8 phases per line. It therefore sees the four-flag layout and the strict threshold of 8 exactly as specified. Because segments are only 16 wide, it can set every zero count on purpose. Lines place 0, 7, 8, 9, 15 and 16 zeros in each segment across the phases, and a line flags one segment per phase to show the flag-to-bits mapping. A short random run of full lines, and a line offered in the middle of a transfer, exercise sequencing and reassembly around the loop.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;

  // Number of zero bits among the lowest w bits of v (w <= 64).
  function automatic int zeros_in(input logic [63:0] v, input int w);
    int n;
    n = 0;
    for (int i = 0; i < 64; i++) begin
      if (i < w && !v[i]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/dbi_seg_enc.sv
module dbi_seg_enc #(
  parameter int SEG_W = 16
) (
  input  logic [SEG_W-1:0] raw,
  output logic [SEG_W-1:0] enc,
  output logic             inv_n
);
  import dbi_pkg::*;

  localparam int LIMIT = SEG_W / 2;

  logic flip;

  always_comb begin
    flip  = zeros_in(64'(raw), SEG_W) > LIMIT;
    enc   = flip ? ~raw : raw;
    inv_n = ~flip;
  end

endmodule

// File: rtl/dbi_seg_dec.sv
module dbi_seg_dec #(
  parameter int SEG_W = 16
) (
  input  logic [SEG_W-1:0] bus,
  input  logic             inv_n,
  output logic [SEG_W-1:0] data
);

  always_comb data = inv_n ? bus : ~bus;

endmodule

// File: rtl/dbi_tx.sv
module dbi_tx #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 16,
  parameter int PHASES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     line_valid,
  input  logic [DATA_W*PHASES-1:0] line,
  output logic                     busy,
  output logic [DATA_W-1:0]        bus,
  output logic [DATA_W/SEG_W-1:0]  inv_n,
  output logic                     phase_valid,
  output logic                     last
);
  import dbi_pkg::*;

  localparam int LINE_W = DATA_W * PHASES;
  localparam int NSEG   = DATA_W / SEG_W;
  localparam int CNT_W  = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(PHASES - 1);

  tx_state_e         state;
  logic [LINE_W-1:0] sreg;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] enc_w;
  logic [NSEG-1:0]   inv_w;

  for (genvar g = 0; g < NSEG; g++) begin : g_enc
    dbi_seg_enc #(.SEG_W(SEG_W)) u_enc (
      .raw   (sreg[g*SEG_W +: SEG_W]),
      .enc   (enc_w[g*SEG_W +: SEG_W]),
      .inv_n (inv_w[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= TX_IDLE;
      sreg        <= '0;
      cnt         <= '0;
      bus         <= '0;
      inv_n       <= '1;
      phase_valid <= 1'b0;
      last        <= 1'b0;
    end else begin
      phase_valid <= 1'b0;
      last        <= 1'b0;
      case (state)
        TX_IDLE: begin
          if (line_valid) begin
            sreg  <= line;
            cnt   <= '0;
            state <= TX_SEND;
          end
        end
        TX_SEND: begin
          bus         <= enc_w;
          inv_n       <= inv_w;
          phase_valid <= 1'b1;
          last        <= (cnt == CNT_END);
          sreg        <= sreg >> DATA_W;
          cnt         <= cnt + 1'b1;
          if (cnt == CNT_END) state <= TX_IDLE;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign busy = (state == TX_SEND);

  // Checks on the registered phase output.
  for (genvar g = 0; g < NSEG; g++) begin : g_chk
    a_r3_low_bound: assert property (@(posedge clk) disable iff (rst)
      phase_valid |-> (zeros_in(64'(bus[g*SEG_W +: SEG_W]), SEG_W) <= SEG_W / 2));

    a_r5_roundtrip: assert property (@(posedge clk) disable iff (rst)
      phase_valid |-> ((inv_n[g] ? bus[g*SEG_W +: SEG_W] : ~bus[g*SEG_W +: SEG_W])
                       == $past(sreg[g*SEG_W +: SEG_W])));
  end

  a_r7_last_valid: assert property (@(posedge clk) disable iff (rst)
    last |-> phase_valid);

  a_r7_last_single: assert property (@(posedge clk) disable iff (rst)
    last |=> !last);

endmodule

// File: rtl/dbi_rx.sv
module dbi_rx #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 16,
  parameter int PHASES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     phase_valid,
  input  logic [DATA_W-1:0]        bus,
  input  logic [DATA_W/SEG_W-1:0]  inv_n,
  output logic [DATA_W*PHASES-1:0] line,
  output logic                     line_valid
);

  localparam int LINE_W = DATA_W * PHASES;
  localparam int ACC_W  = LINE_W - DATA_W;
  localparam int NSEG   = DATA_W / SEG_W;
  localparam int CNT_W  = $clog2(PHASES);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(PHASES - 1);

  logic [DATA_W-1:0] dec_w;
  logic [ACC_W-1:0]  acc;
  logic [CNT_W-1:0]  cnt;

  for (genvar g = 0; g < NSEG; g++) begin : g_dec
    dbi_seg_dec #(.SEG_W(SEG_W)) u_dec (
      .bus   (bus[g*SEG_W +: SEG_W]),
      .inv_n (inv_n[g]),
      .data  (dec_w[g*SEG_W +: SEG_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      cnt        <= '0;
      line       <= '0;
      line_valid <= 1'b0;
    end else begin
      line_valid <= 1'b0;
      if (phase_valid) begin
        if (cnt == CNT_END) begin
          line       <= {dec_w, acc};
          line_valid <= 1'b1;
          cnt        <= '0;
        end else begin
          acc <= {dec_w, acc[ACC_W-1:DATA_W]};
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r9_line_pulse: assert property (@(posedge clk) disable iff (rst)
    line_valid |=> !line_valid);

endmodule

// File: rtl/dbi_line_codec.sv
module dbi_line_codec #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 16,
  parameter int PHASES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tx_line_valid,
  input  logic [DATA_W*PHASES-1:0] tx_line,
  output logic                     tx_busy,
  output logic [DATA_W-1:0]        tx_bus,
  output logic [DATA_W/SEG_W-1:0]  tx_inv_n,
  output logic                     tx_phase_valid,
  output logic                     tx_last,
  input  logic                     rx_phase_valid,
  input  logic [DATA_W-1:0]        rx_bus,
  input  logic [DATA_W/SEG_W-1:0]  rx_inv_n,
  output logic [DATA_W*PHASES-1:0] rx_line,
  output logic                     rx_line_valid
);

  dbi_tx #(.DATA_W(DATA_W), .SEG_W(SEG_W), .PHASES(PHASES)) u_tx (
    .clk         (clk),
    .rst         (rst),
    .line_valid  (tx_line_valid),
    .line        (tx_line),
    .busy        (tx_busy),
    .bus         (tx_bus),
    .inv_n       (tx_inv_n),
    .phase_valid (tx_phase_valid),
    .last        (tx_last)
  );

  dbi_rx #(.DATA_W(DATA_W), .SEG_W(SEG_W), .PHASES(PHASES)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .phase_valid (rx_phase_valid),
    .bus         (rx_bus),
    .inv_n       (rx_inv_n),
    .line        (rx_line),
    .line_valid  (rx_line_valid)
  );

  a_r10_idle_flags: assert property (@(posedge clk) disable iff (rst)
    !tx_busy && !tx_phase_valid |-> $stable(tx_inv_n) || $past(tx_phase_valid));

endmodule

// File: tb/dbi_line_codec_tb.sv
`timescale 1ns/1ps
module dbi_line_codec_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tx_line_valid = 1'b0;
  logic [511:0] tx_line = '0;
  logic         tx_busy;
  logic [63:0]  tx_bus;
  logic [3:0]   tx_inv_n;
  logic         tx_phase_valid;
  logic         tx_last;
  logic [511:0] rx_line;
  logic         rx_line_valid;

  int checks = 0;
  int errors = 0;
  logic [63:0] obs_bus [8];
  logic [3:0]  obs_inv [8];

  always #5 clk = ~clk;

  dbi_line_codec u_dut (
    .clk            (clk),
    .rst            (rst),
    .tx_line_valid  (tx_line_valid),
    .tx_line        (tx_line),
    .tx_busy        (tx_busy),
    .tx_bus         (tx_bus),
    .tx_inv_n       (tx_inv_n),
    .tx_phase_valid (tx_phase_valid),
    .tx_last        (tx_last),
    .rx_phase_valid (tx_phase_valid),
    .rx_bus         (tx_bus),
    .rx_inv_n       (tx_inv_n),
    .rx_line        (rx_line),
    .rx_line_valid  (rx_line_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lows16(input logic [15:0] v);
    int n = 0;
    for (int i = 0; i < 16; i++) if (v[i] == 1'b0) n++;
    return n;
  endfunction

  function automatic logic [15:0] seg_with(input int n);
    logic [15:0] s;
    for (int i = 0; i < 16; i++) s[i] = (i >= n);
    return s;
  endfunction

  task automatic ref_enc(input logic [63:0] d, output logic [63:0] b, output logic [3:0] f);
    for (int g = 0; g < 4; g++) begin
      if (lows16(d[g*16 +: 16]) > 8) begin
        b[g*16 +: 16] = ~d[g*16 +: 16];
        f[g] = 1'b0;
      end else begin
        b[g*16 +: 16] = d[g*16 +: 16];
        f[g] = 1'b1;
      end
    end
  endtask

  // Send one line; optionally offer another line while busy (R8).
  task automatic run_line(input logic [511:0] ln, input bit poke, input logic [511:0] other);
    logic [63:0] eb;
    logic [3:0]  ef;
    @(negedge clk);
    tx_line_valid = 1'b1;
    tx_line       = ln;
    @(negedge clk);
    tx_line_valid = 1'b0;
    chk(tx_busy == 1'b1 && tx_phase_valid == 1'b0, "R6 accept latency", {tx_busy, tx_phase_valid}, 2'b10);
    for (int k = 0; k < 8; k++) begin
      if (poke && k == 2) begin
        tx_line_valid = 1'b1;
        tx_line       = other;
      end else begin
        tx_line_valid = 1'b0;
      end
      @(negedge clk);
      ref_enc(ln[k*64 +: 64], eb, ef);
      obs_bus[k] = tx_bus;
      obs_inv[k] = tx_inv_n;
      chk(tx_phase_valid == 1'b1, "R6 phase valid", tx_phase_valid, 1);
      chk(tx_bus == eb && tx_inv_n == ef, "R2 R6 R11 phase encoding", {tx_inv_n, tx_bus}, {ef, eb});
      chk(tx_last == (k == 7), "R7 last position", tx_last, (k == 7));
      for (int g = 0; g < 4; g++)
        chk(lows16(tx_bus[g*16 +: 16]) <= 8, "R3 low wires bounded", lows16(tx_bus[g*16 +: 16]), 8);
    end
    tx_line_valid = 1'b0;
    @(negedge clk);
    chk(rx_line_valid == 1'b1, "R9 line valid pulse", rx_line_valid, 1);
    chk(rx_line == ln, "R5 R9 round trip line", rx_line, ln);
    chk(tx_phase_valid == 1'b0, "R8 no extra phase", tx_phase_valid, 0);
    @(negedge clk);
    chk(rx_line_valid == 1'b0, "R9 single pulse", rx_line_valid, 0);
    chk(tx_phase_valid == 1'b0 && tx_busy == 1'b0, "R8 offered line dropped", {tx_busy, tx_phase_valid}, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(tx_phase_valid == 0 && tx_last == 0 && tx_busy == 0 && rx_line_valid == 0,
        "R10 reset controls", {tx_phase_valid, tx_last, tx_busy, rx_line_valid}, 0);
    chk(tx_inv_n == 4'hF, "R10 reset flags", tx_inv_n, 4'hF);
  endtask

  task automatic t_random();
    logic [511:0] ln;
    for (int n = 0; n < 6; n++) begin
      for (int w = 0; w < 16; w++) ln[w*32 +: 32] = $urandom;
      run_line(ln, 1'b0, '0);
    end
  endtask

  task automatic t_threshold();
    int cnts [8] = '{8, 9, 16, 0, 7, 15, 1, 8};
    logic [511:0] ln;
    int n;
    for (int k = 0; k < 8; k++)
      for (int g = 0; g < 4; g++)
        ln[k*64 + g*16 +: 16] = seg_with(cnts[(k + g) % 8]);
    run_line(ln, 1'b0, '0);
    for (int k = 0; k < 8; k++)
      for (int g = 0; g < 4; g++) begin
        n = cnts[(k + g) % 8];
        chk(obs_inv[k][g] == (n <= 8), "R2 strict threshold flag", obs_inv[k][g], (n <= 8));
        if (n == 16)
          chk(obs_bus[k][g*16 +: 16] == 16'hFFFF && obs_inv[k][g] == 1'b0,
              "R4 all-zero segment", {obs_inv[k][g], obs_bus[k][g*16 +: 16]}, 17'h0FFFF);
      end
  endtask

  task automatic t_mapping();
    logic [511:0] ln;
    logic [3:0] ef;
    for (int k = 0; k < 8; k++)
      for (int g = 0; g < 4; g++)
        ln[k*64 + g*16 +: 16] = (g == k % 4) ? seg_with(9) : 16'hFFFF;
    run_line(ln, 1'b0, '0);
    for (int k = 0; k < 8; k++) begin
      ef = ~(4'b0001 << (k % 4));
      chk(obs_inv[k] == ef, "R1 flag to segment mapping", obs_inv[k], ef);
    end
  endtask

  task automatic t_busy();
    logic [511:0] a;
    logic [511:0] b;
    for (int w = 0; w < 16; w++) begin
      a[w*32 +: 32] = $urandom;
      b[w*32 +: 32] = ~a[w*32 +: 32];
    end
    run_line(a, 1'b1, b);
  endtask

  initial begin
    t_reset();
    t_random();
    t_threshold();
    t_mapping();
    t_busy();
    t_random();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule